// File: doc/BRIEF.md
# CPU Frame Injection Assembler

This block takes frames that a processor writes one 32-bit word at a time and turns them into a byte stream with start and end markers for a switch core. The processor frames its writes with a control port. A start command opens a frame and sets the idle gap that follows it. The processor then writes a fixed number of header words and the payload words. An end command gives the number of valid bytes in the last payload word. One final data write follows it, a CRC placeholder word, and that word closes the frame.

The words wait in a FIFO. A serializer sends each word most significant byte first. It flags the header bytes, the first byte of the frame and the last byte of the frame. After each frame it leaves the programmed number of idle cycles. The processor polls two status outputs. `fifo_ready` says that another frame of the largest size fits. `wm_reached` is a sticky flag that the block sets when the buffered word count reaches a threshold. It stays set until `wm_clear` is pulsed. A data write that arrives while no frame is open is dropped and sets a sticky error flag. The writer zero-pads frames shorter than 60 bytes to 15 payload words. For such frames the writer gives 0 as the valid-byte count.

Top module: `inj_frame_assembler`

## Requirements
- R1: After reset, `out_valid`, `wm_reached` and `orphan_err` are 0 and `fifo_ready` is 1.
- R2: A control write with `ctrl_sof`=1 opens a frame only when `ctrl_gap` is nonzero. A start with `ctrl_gap`=0 is ignored, so the data writes after it are treated as orphans.
- R3: The first `HDR_WORDS` data words of a frame come out first with `out_hdr`=1. `out_sof`=1 marks only the first byte of the frame.
- R4: Each word is emitted as four bytes in the order data[31:24], data[23:16], data[15:8], data[7:0].
- R5: The end command's `ctrl_vld` trims the last payload word. A value of 0 keeps all 4 bytes. A value of n from 1 to 3 keeps the first n bytes. Zero-padded words are emitted in full.
- R6: The data word written after the end command is emitted in full, with `out_eof`=1 on its fourth byte only. That write closes the frame.
- R7: A data write while no frame is open produces no output byte and sets `orphan_err`. `orphan_err` stays set until reset.
- R8: After the byte that carries `out_eof` has been accepted, `out_valid` stays low for at least `ctrl_gap` cycles, the gap given at the frame's start.
- R9: While `out_valid`=1 and `out_ready`=0, the byte and its markers hold steady.
- R10: `fifo_ready` is 1 exactly when the free FIFO words number at least `MAX_FRAME_WORDS`.
- R11: `wm_reached` sets when the FIFO holds at least `WM_LEVEL` words. It stays set until a cycle with `wm_clear`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_sof | input | 1 | Start-of-frame command |
| ctrl_eof | input | 1 | End-of-frame command |
| ctrl_vld | input | 2 | Valid bytes in the last payload word (0 means 4) |
| ctrl_gap | input | 2 | Idle cycles after the frame; must be nonzero at start |
| data_we | input | 1 | Data write strobe |
| data_wdata | input | 32 | Data word |
| wm_clear | input | 1 | Clears the watermark flag |
| out_ready | input | 1 | Sink accepts a byte |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_hdr | output | 1 | Byte belongs to the header |
| fifo_ready | output | 1 | Room for one maximum-size frame |
| wm_reached | output | 1 | Sticky watermark flag |
| orphan_err | output | 1 | Sticky orphan data write flag |

## Verification
The assertions assume a well-behaved writer. It never issues a control write and a data write in the same cycle. It never writes a word when the FIFO is full. It always gives a nonzero gap with each start it means to use. The bench keeps to these rules by writing frames only after `fifo_ready` is high and by driving one strobe per cycle. Its largest backlog, three 18-word frames with the sink stalled, stays below the FIFO depth. The gap-0 start and the orphan data write are deliberate violations of the framing protocol, not of these assumptions, and the design is required to handle both.

// File: rtl/inj_pkg.sv
// Package for the injection assembler.
// It defines the word record that passes from the frame writer, through the FIFO, to the byte serializer.
// Assumes a 32-bit data word sent as four bytes.
package inj_pkg;
    localparam int WORD_BYTES = 4;
    localparam int GAP_W      = 2;

    typedef struct packed {
        logic [8*WORD_BYTES-1:0] data;   // word, most significant byte sent first
        logic                    first;  // first word of the frame
        logic                    last;   // CRC placeholder word, closes the frame
        logic                    hdr;    // header word
        logic [1:0]              nbm1;   // bytes to send minus one
        logic [GAP_W-1:0]        gap;    // idle cycles after the frame
    } inj_word_t;
endpackage

// File: rtl/inj_word_fifo.sv
// Show-ahead FIFO for word records, with a fill level output.
// Assumes DEPTH is a power of two. A push into a full FIFO is dropped; the writer is expected never to do this.
module inj_word_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 43,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic [LW-1:0]    level
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (level == '0);
    assign do_push = push && (level != LW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write; the array has no reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level != LW'(DEPTH)));                                // R10
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (level == $past(level) + 1'b1));             // R11
endmodule

// File: rtl/inj_frame_writer.sv
// Frame writer: decodes the control and data writes from the processor into word records.
// The newest word waits in a one-word stage so that a later end command can still trim it.
// The CRC placeholder word is pushed alone, in the cycle after it is written.
// Assumes that control and data writes never come in the same cycle.
module inj_frame_writer
    import inj_pkg::*;
#(
    parameter int HDR_WORDS = 2,
    localparam int HW = $clog2(HDR_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             ctrl_sof,
    input  logic             ctrl_eof,
    input  logic [1:0]       ctrl_vld,
    input  logic [GAP_W-1:0] ctrl_gap,
    input  logic             data_we,
    input  logic [31:0]      data_wdata,
    output logic             push,
    output inj_word_t        push_word,
    output logic             orphan_err
);
    typedef enum logic [1:0] {W_IDLE, W_OPEN, W_TAIL} wr_state_t;

    wr_state_t        state;
    inj_word_t        stage;
    logic             stage_v;
    logic             first_pend;
    logic [HW-1:0]    hdr_cnt;
    logic [GAP_W-1:0] gap_r;

    // Push the staged word when a newer word replaces it, or when it is the closing word
    always_comb begin
        push_word = stage;
        push      = stage_v && (stage.last || (data_we && state != W_IDLE));
    end

    // Framing state, staging register and orphan flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            stage      <= '0;
            stage_v    <= 1'b0;
            first_pend <= 1'b0;
            hdr_cnt    <= '0;
            gap_r      <= '0;
            orphan_err <= 1'b0;
        end else begin
            if (stage_v && stage.last) stage_v <= 1'b0;
            case (state)
                W_IDLE: begin
                    if (ctrl_we && ctrl_sof && ctrl_gap != '0) begin
                        state      <= W_OPEN;
                        hdr_cnt    <= '0;
                        first_pend <= 1'b1;
                        gap_r      <= ctrl_gap;
                    end
                    if (data_we) orphan_err <= 1'b1;
                end
                W_OPEN: begin
                    if (data_we) begin
                        stage.data  <= data_wdata;
                        stage.first <= first_pend;
                        stage.last  <= 1'b0;
                        stage.hdr   <= (hdr_cnt < HW'(HDR_WORDS));
                        stage.nbm1  <= 2'd3;
                        stage.gap   <= gap_r;
                        stage_v     <= 1'b1;
                        first_pend  <= 1'b0;
                        if (hdr_cnt < HW'(HDR_WORDS)) hdr_cnt <= hdr_cnt + 1'b1;
                    end else if (ctrl_we && ctrl_eof) begin
                        stage.nbm1 <= 2'(ctrl_vld - 2'd1);
                        state      <= W_TAIL;
                    end
                end
                W_TAIL: begin
                    if (data_we) begin
                        stage.data  <= data_wdata;
                        stage.first <= 1'b0;
                        stage.last  <= 1'b1;
                        stage.hdr   <= 1'b0;
                        stage.nbm1  <= 2'd3;
                        stage.gap   <= gap_r;
                        stage_v     <= 1'b1;
                        state       <= W_IDLE;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    AST_ORPHAN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        orphan_err |=> orphan_err);                                     // R7
    AST_ORPHAN_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && state == W_IDLE && !stage_v) |-> !push);            // R7
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_we && data_we));                                         // R2
endmodule

// File: rtl/inj_byte_serializer.sv
// Byte serializer: takes word records from the FIFO and sends their bytes most significant first.
// It marks the header bytes and the frame edges, and leaves the programmed idle gap after each frame.
// Assumes the FIFO read data is valid in the same cycle whenever the FIFO is not empty.
module inj_byte_serializer
    import inj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_empty,
    input  inj_word_t  fifo_rd_word,
    output logic       fifo_pop,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_hdr
);
    inj_word_t        cur;
    logic             cur_v;
    logic [1:0]       idx;
    logic [GAP_W-1:0] gap_cnt;
    logic             xfer, last_byte, adv;
    logic [1:0]       byte_sel;

    // Output decode of the current word and byte index
    always_comb begin
        last_byte = (idx == cur.nbm1);
        out_valid = cur_v && (gap_cnt == '0);
        xfer      = out_valid && out_ready;
        adv       = !cur_v || (xfer && last_byte);
        fifo_pop  = adv && !fifo_empty;
        byte_sel  = 2'd3 - idx;
        out_data  = cur.data[{byte_sel, 3'b000} +: 8];
        out_sof   = cur_v && cur.first && (idx == 2'd0);
        out_eof   = cur_v && cur.last && last_byte;
        out_hdr   = cur_v && cur.hdr;
    end

    // Word register and byte index advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            cur_v <= 1'b0;
            idx   <= '0;
        end else if (adv) begin
            cur_v <= !fifo_empty;
            if (!fifo_empty) cur <= fifo_rd_word;
            idx   <= '0;
        end else if (xfer) begin
            idx <= idx + 1'b1;
        end
    end

    // Inter-frame idle gap counter
    always_ff @(posedge clk) begin
        if (!rst_n)                         gap_cnt <= '0;
        else if (xfer && out_eof)           gap_cnt <= cur.gap;
        else if (gap_cnt != '0)             gap_cnt <= gap_cnt - 1'b1;
    end

    AST_GAP_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);            // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_eof) && $stable(out_sof))); // R9
    AST_SOF_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_hdr);                                           // R3
endmodule

// File: rtl/inj_frame_assembler.sv
// Top level of the processor frame injection assembler.
// It connects the frame writer, the word FIFO and the byte serializer, and it produces the
// ready and watermark status from the FIFO level.
// Assumes the writer polls fifo_ready before starting each frame.
module inj_frame_assembler
    import inj_pkg::*;
#(
    parameter int FIFO_DEPTH      = 64,
    parameter int HDR_WORDS       = 2,
    parameter int MAX_FRAME_WORDS = 24,
    parameter int WM_LEVEL        = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_we,
    input  logic        ctrl_sof,
    input  logic        ctrl_eof,
    input  logic [1:0]  ctrl_vld,
    input  logic [1:0]  ctrl_gap,
    input  logic        data_we,
    input  logic [31:0] data_wdata,
    input  logic        wm_clear,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_sof,
    output logic        out_eof,
    output logic        out_hdr,
    output logic        fifo_ready,
    output logic        wm_reached,
    output logic        orphan_err
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam int WW = $bits(inj_word_t);

    logic      push, pop, empty;
    inj_word_t push_word, rd_word;
    logic [LW-1:0] level;
    logic [LW-1:0] free_words;

    inj_frame_writer #(.HDR_WORDS(HDR_WORDS)) u_writer (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_sof(ctrl_sof), .ctrl_eof(ctrl_eof),
        .ctrl_vld(ctrl_vld), .ctrl_gap(ctrl_gap),
        .data_we(data_we), .data_wdata(data_wdata),
        .push(push), .push_word(push_word), .orphan_err(orphan_err)
    );

    inj_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WW)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .wdata(push_word),
        .pop(pop), .rdata(rd_word),
        .empty(empty), .level(level)
    );

    inj_byte_serializer u_ser (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(empty), .fifo_rd_word(rd_word), .fifo_pop(pop),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_hdr(out_hdr)
    );

    // Room for one more maximum-size frame
    always_comb begin
        free_words = LW'(FIFO_DEPTH) - level;
        fifo_ready = (free_words >= LW'(MAX_FRAME_WORDS));
    end

    // Sticky watermark flag; a clear wins over a new set
    always_ff @(posedge clk) begin
        if (!rst_n)                           wm_reached <= 1'b0;
        else if (wm_clear)                    wm_reached <= 1'b0;
        else if (level >= LW'(WM_LEVEL))      wm_reached <= 1'b1;
    end

    AST_WM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_reached && !wm_clear) |=> wm_reached);                      // R11
    AST_WM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wm_clear |=> !wm_reached);                                      // R11
endmodule

// File: tb/inj_frame_assembler_test.sv
module inj_frame_assembler_test;
    localparam int HDR_WORDS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 0, ctrl_sof = 0, ctrl_eof = 0;
    logic [1:0] ctrl_vld = 0, ctrl_gap = 0;
    logic data_we = 0;
    logic [31:0] data_wdata = 0;
    logic wm_clear = 0, out_ready = 1;
    logic out_valid, out_sof, out_eof, out_hdr, fifo_ready, wm_reached, orphan_err;
    logic [7:0] out_data;

    int checks = 0;
    int fails = 0;
    logic [10:0] exp_q[$];   // {hdr, sof, eof, byte}
    int exp_gap = 0;
    int idle_cnt = 0;
    logic after_eof = 0;
    logic prev_stall = 0;
    logic [7:0] prev_data = 0;

    always #4 clk = ~clk;

    inj_frame_assembler uut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_sof(ctrl_sof), .ctrl_eof(ctrl_eof),
        .ctrl_vld(ctrl_vld), .ctrl_gap(ctrl_gap),
        .data_we(data_we), .data_wdata(data_wdata),
        .wm_clear(wm_clear), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_hdr(out_hdr), .fifo_ready(fifo_ready),
        .wm_reached(wm_reached), .orphan_err(orphan_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic sof, input logic eof, input logic [1:0] vld, input logic [1:0] gap);
        @(posedge clk); #1;
        ctrl_we = 1; ctrl_sof = sof; ctrl_eof = eof; ctrl_vld = vld; ctrl_gap = gap;
        @(posedge clk); #1;
        ctrl_we = 0; ctrl_sof = 0; ctrl_eof = 0;
    endtask

    task automatic data_write(input logic [31:0] w);
        @(posedge clk); #1;
        data_we = 1; data_wdata = w;
        @(posedge clk); #1;
        data_we = 0;
    endtask

    // Driver: writes one frame and pushes the expected bytes to the scoreboard
    task automatic send_frame(input int len, input logic [7:0] seed, input logic [1:0] gap);
        int nwords, vld, keep;
        logic [7:0] b;
        logic [31:0] w;
        nwords = (len + 3) / 4;
        if (nwords < 15) nwords = 15;
        vld = (len < 60) ? 0 : (len % 4);
        ctrl_write(1'b1, 1'b0, 2'd0, gap);
        for (int h = 0; h < HDR_WORDS; h++) begin
            w = {8'hA0 + 8'(h), seed, 8'h5A, 8'(h)};
            data_write(w);
            for (int k = 0; k < 4; k++)   // R3, R4: header bytes first, MSB first
                exp_q.push_back({1'b1, (h == 0 && k == 0), 1'b0, w[31-8*k -: 8]});
        end
        for (int i = 0; i < nwords; i++) begin
            for (int k = 0; k < 4; k++) begin
                b = (4*i + k < len) ? 8'(seed + 8'(4*i + k) + 8'd1) : 8'h00;
                w[31-8*k -: 8] = b;
            end
            data_write(w);
            keep = (i == nwords - 1 && vld != 0) ? vld : 4;   // R5
            for (int k = 0; k < keep; k++)
                exp_q.push_back({1'b0, 1'b0, 1'b0, w[31-8*k -: 8]});
        end
        ctrl_write(1'b0, 1'b1, 2'(vld), 2'd0);
        data_write(32'h0);
        for (int k = 0; k < 4; k++)   // R6
            exp_q.push_back({1'b0, 1'b0, (k == 3), 8'h00});
    endtask

    task automatic drain();
        int n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 5000) begin
            @(posedge clk); #1;
            n++;
        end
        repeat (6) @(posedge clk);
        #1;
    endtask

    // Monitor: pops expected bytes and compares them with the stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall && out_valid)
                check("R9 stalled byte held", {24'h0, out_data}, {24'h0, prev_data});
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (after_eof) begin
                    check("R8 idle gap", {31'h0, (idle_cnt >= exp_gap)}, 32'h1);
                    after_eof = 0;
                end
                if (exp_q.size() == 0) begin
                    check("R7 unexpected byte", {21'h0, out_hdr, out_sof, out_eof, out_data}, 32'hFFFF);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    check("R3 R4 R5 R6 stream byte", {21'h0, out_hdr, out_sof, out_eof, out_data}, {21'h0, e});
                end
                if (out_eof) begin
                    after_eof = 1;
                    idle_cnt = 0;
                end
            end else if (!out_valid && after_eof) begin
                idle_cnt++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 fifo_ready", fifo_ready, 1);
        check("R1 wm_reached", wm_reached, 0);
        check("R1 orphan_err", orphan_err, 0);

        // R2: a start with gap 0 opens nothing, so the next data write is an orphan
        ctrl_write(1'b1, 1'b0, 2'd0, 2'd0);
        data_write(32'hDEADBEEF);
        repeat (8) @(posedge clk);
        @(negedge clk);
        check("R2 gap-0 start ignored", orphan_err, 1);
        check("R7 orphan dropped", out_valid, 0);

        // Short padded frame, gap 1
        exp_gap = 1;
        send_frame(5, 8'h10, 2'd1);
        drain();

        // Long frame, vld 2, with sink stalls
        exp_gap = 3;
        send_frame(70, 8'h40, 2'd3);
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            out_ready = (i % 3 != 0);
        end
        out_ready = 1;
        drain();

        // Back-to-back frames, vld 0 and vld 1
        exp_gap = 2;
        send_frame(64, 8'h80, 2'd2);
        send_frame(61, 8'hC0, 2'd2);
        drain();

        // R10, R11: backlog with the sink stalled
        out_ready = 0;
        exp_gap = 1;
        send_frame(60, 8'h20, 2'd1);
        send_frame(60, 8'h30, 2'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 ready with room", fifo_ready, 1);
        check("R11 below watermark", wm_reached, 0);
        send_frame(60, 8'h50, 2'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 not ready when full", fifo_ready, 0);
        check("R11 watermark set", wm_reached, 1);
        @(posedge clk); #1;
        out_ready = 1;
        drain();
        check("R11 watermark sticky", wm_reached, 1);
        check("R10 ready after drain", fifo_ready, 1);
        @(posedge clk); #1 wm_clear = 1;
        @(posedge clk); #1 wm_clear = 0;
        @(negedge clk);
        check("R11 watermark cleared", wm_reached, 0);
        check("R7 orphan sticky", orphan_err, 1);
        check("R6 all bytes seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule